// File: doc/BRIEF.md
# Streaming Header Section Tagger

The block receives an Ethernet frame one byte per cycle, framed by start and end markers. For every byte inside a frame it reports, one cycle later, three things:

- an 8-bit section code naming the protocol region the byte belongs to;
- the byte's offset inside that region;
- the IP tunnel depth at which the region sits.

The block walks the Ethernet header first. It then follows IPv4 headers and IPv6 fixed headers, the IPv6 extension-header chain, and nested IP-in-IP headers, and finishes with the transport header and the application payload. Every region therefore sits at an offset that is only known once the bytes before it have been seen.

For each frame the block also records where certain regions first begin, measured in bytes from the first byte of the frame, with a valid flag per record. The recorded regions are:

- the IPv6 header and the IPv4 header;
- the first transport or ICMP header;
- the payload;
- the six IPv6 extension headers.

A downstream matcher uses the section code, the in-section offset and these start records to anchor patterns to header fields or payload at variable positions.

Top module: `hdr_section_tagger`

## Requirements
- R1: Each byte accepted inside a frame (inValid high, and either inSof high or a frame already open) yields one tag on the next cycle, with outValid high. Bytes offered after inEof and before the next inSof yield no tag and change no state.
- R2: The 14 Ethernet header bytes carry code 0xFD and tunnel 0. The ethertype at frame bytes 12-13 selects the next region: 0x0800 gives IPv4 (0x04) at frame offset 14, 0x86DD gives IPv6 (0x29), and any other value gives unknown (0xFF) up to the end of the frame.
- R3: outOffset is 0 on the first byte of every region and rises by one per tagged byte within that region.
- R4: An IPv4 header (0x04) is 4 × the low nibble of its byte 0 long, and its byte 9 names the next region. An IPv6 header (0x29) is 40 bytes long, and its byte 6 names the next region.
- R5: Hop-by-Hop (0x00), Routing (0x2B) and Destination (0x3C) headers are (byte 1 + 1) × 8 long. Fragment (0x2C) is 8 long. Authentication (0x33) is (byte 1 + 2) × 4 long. In all five, byte 0 names the next region.
- R6: TCP (0x06) is 4 × the high nibble of its byte 12 long, and UDP (0x11) is 8 long. Both are followed by payload (0xFE) up to the end of the frame.
- R7: ICMPv4 (0x01), ICMPv6 (0x3A) and ESP (0x32) continue to the end of the frame. A next-region number outside the recognised set (for example 59) gives unknown (0xFF) up to the end of the frame.
- R8: The tunnel depth is 0 for the outermost IP header. It rises by one on the first byte of each IPv4 or IPv6 header named by a next-region number of 4 or 41. When the depth is already 3, such a header is tagged unknown instead and the depth stays 3.
- R9: The first byte of the first occurrence of each recorded region latches its frame offset and sets its valid flag. The slots are 0 IPv6, 1 IPv4, 2 first TCP/UDP/ICMPv4/ICMPv6, 3 payload, 4 Hop-by-Hop, 5 Routing, 6 Fragment, 7 Destination, 8 Authentication, 9 ESP. Later occurrences leave the slot untouched. The new value is visible together with that byte's tag.
- R10: inSof, even in the middle of an open frame, restarts parsing at the Ethernet header with tunnel 0. From the tag of that byte onward, every start record and valid flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Byte present on inByte |
| inSof | input | 1 | First byte of a frame |
| inEof | input | 1 | Last byte of a frame |
| inByte | input | 8 | Frame byte |
| outValid | output | 1 | Tag present for the byte accepted one cycle earlier |
| outCode | output | 8 | Section code of that byte |
| outOffset | output | OFF_W | Offset of that byte inside its section |
| outTunnel | output | TUN_W | Tunnel depth of that byte |
| startOffsets | output | 10×OFF_W | Frame offset of each recorded region, slot s at bits s×OFF_W upward |
| startValid | output | 10 | Per-slot record valid |

## Verification
The bench drives the following frames:

- a full six-deep IPv6 extension chain with a repeated Destination header;
- IPv4 with options;
- a four-level tunnel stack whose fifth header must turn unknown;
- foreign ethertypes and unrecognised next-header values;
- ESP and ICMP tails;
- the same frame with idle gaps between bytes;
- stray bytes between frames;
- a frame cut short by a new start marker.

These frames are aimed at specific faults:

- A design that read a length field a byte late, or used the wrong multiplier, would shift every later boundary. This shows up as wrong codes and offsets from that point onward.
- A design that overwrote a start record on a second Destination header would report the later offset.
- A design that failed to saturate the tunnel depth would wrap it or tag a fifth IP header as a header.
- A design that kept state across the start marker would carry the old tunnel depth or stale valid flags into the new frame.

// File: rtl/hdr_tagger_pkg.sv
package hdr_tagger_pkg;

  localparam int NUM_SLOTS = 10;

  localparam logic [7:0] SEC_HOPOPT  = 8'h00;
  localparam logic [7:0] SEC_ICMP4   = 8'h01;
  localparam logic [7:0] SEC_IPV4    = 8'h04;
  localparam logic [7:0] SEC_TCP     = 8'h06;
  localparam logic [7:0] SEC_UDP     = 8'h11;
  localparam logic [7:0] SEC_IPV6    = 8'h29;
  localparam logic [7:0] SEC_ROUTE   = 8'h2B;
  localparam logic [7:0] SEC_FRAG    = 8'h2C;
  localparam logic [7:0] SEC_ESP     = 8'h32;
  localparam logic [7:0] SEC_AUTH    = 8'h33;
  localparam logic [7:0] SEC_ICMP6   = 8'h3A;
  localparam logic [7:0] SEC_DSTOPT  = 8'h3C;
  localparam logic [7:0] SEC_ETH     = 8'hFD;
  localparam logic [7:0] SEC_PAYLOAD = 8'hFE;
  localparam logic [7:0] SEC_UNKNOWN = 8'hFF;

  localparam logic [15:0] ETYPE_V4 = 16'h0800;
  localparam logic [15:0] ETYPE_V6 = 16'h86DD;
  localparam logic [15:0] ETH_LEN  = 16'd14;

  // strobes from control to datapath for the byte on the input this cycle
  typedef struct packed {
    logic       take;      // byte is tagged
    logic       restart;   // byte opens a new frame
    logic [7:0] code;      // section of this byte
    logic [7:0] nextCode;  // section after this one if this byte closes it
  } dpCtl_t;

  // sections whose length is known from their own bytes
  function automatic logic isBounded(input logic [7:0] c);
    case (c)
      SEC_ETH, SEC_IPV4, SEC_IPV6, SEC_HOPOPT, SEC_ROUTE, SEC_FRAG,
      SEC_DSTOPT, SEC_AUTH, SEC_TCP, SEC_UDP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // next-header numbers followed without a tunnel step
  function automatic logic isPlainProto(input logic [7:0] c);
    case (c)
      SEC_HOPOPT, SEC_ICMP4, SEC_TCP, SEC_UDP, SEC_ROUTE, SEC_FRAG,
      SEC_ESP, SEC_AUTH, SEC_ICMP6, SEC_DSTOPT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic isExtHdr(input logic [7:0] c);
    case (c)
      SEC_HOPOPT, SEC_ROUTE, SEC_FRAG, SEC_DSTOPT, SEC_AUTH: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // length assumed on entry, before any length field has been read
  function automatic logic [15:0] entryLen(input logic [7:0] c);
    case (c)
      SEC_IPV4, SEC_TCP: return 16'd20;
      SEC_IPV6:          return 16'd40;
      SEC_ETH:           return ETH_LEN;
      default:           return 16'd8;
    endcase
  endfunction

  function automatic logic [NUM_SLOTS-1:0] slotHit(input logic [7:0] c);
    logic [NUM_SLOTS-1:0] m;
    m = '0;
    case (c)
      SEC_IPV6:                                m[0] = 1'b1;
      SEC_IPV4:                                m[1] = 1'b1;
      SEC_TCP, SEC_UDP, SEC_ICMP4, SEC_ICMP6:  m[2] = 1'b1;
      SEC_PAYLOAD:                             m[3] = 1'b1;
      SEC_HOPOPT:                              m[4] = 1'b1;
      SEC_ROUTE:                               m[5] = 1'b1;
      SEC_FRAG:                                m[6] = 1'b1;
      SEC_DSTOPT:                              m[7] = 1'b1;
      SEC_AUTH:                                m[8] = 1'b1;
      SEC_ESP:                                 m[9] = 1'b1;
      default:                                 m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hdr_tagger_ctrl.sv
module hdr_tagger_ctrl
  import hdr_tagger_pkg::*;
#(
  parameter int TUNNEL_MAX = 3,
  parameter int TUN_W      = $clog2(TUNNEL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [7:0]       inByte,
  input  logic             secLast,
  input  logic [7:0]       nhByte,
  output dpCtl_t           ctl,
  output logic             outValid,
  output logic [7:0]       outCode,
  output logic [TUN_W-1:0] outTunnel
);

  localparam logic [TUN_W-1:0] TUN_CAP = TUN_W'(TUNNEL_MAX);

  logic             inFrame;
  logic [7:0]       curCode;
  logic [TUN_W-1:0] tunnel;

  logic             take;
  logic [7:0]       effCode;
  logic [TUN_W-1:0] effTun;
  logic [7:0]       nxtCode;
  logic [TUN_W-1:0] nxtTun;

  assign take    = inValid && (inSof || inFrame);
  assign effCode = inSof ? SEC_ETH : curCode;
  assign effTun  = inSof ? '0 : tunnel;

  // region following the one that closes on this byte
  always_comb begin
    nxtCode = SEC_UNKNOWN;
    nxtTun  = effTun;
    case (effCode)
      SEC_ETH: begin
        if ({nhByte, inByte} == ETYPE_V4)      nxtCode = SEC_IPV4;
        else if ({nhByte, inByte} == ETYPE_V6) nxtCode = SEC_IPV6;
        else                                   nxtCode = SEC_UNKNOWN;
      end
      SEC_TCP, SEC_UDP: nxtCode = SEC_PAYLOAD;
      default: begin
        if (nhByte == SEC_IPV4 || nhByte == SEC_IPV6) begin
          if (effTun == TUN_CAP) begin
            nxtCode = SEC_UNKNOWN;
          end else begin
            nxtCode = nhByte;
            nxtTun  = effTun + 1'b1;
          end
        end else if (isPlainProto(nhByte)) begin
          nxtCode = nhByte;
        end
      end
    endcase
  end

  always_comb begin
    ctl.take     = take;
    ctl.restart  = inValid && inSof;
    ctl.code     = effCode;
    ctl.nextCode = nxtCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      curCode   <= SEC_UNKNOWN;
      tunnel    <= '0;
      outValid  <= 1'b0;
      outCode   <= SEC_UNKNOWN;
      outTunnel <= '0;
    end else begin
      outValid <= take;
      if (take) begin
        inFrame   <= !inEof;
        curCode   <= secLast ? nxtCode : effCode;
        tunnel    <= secLast ? nxtTun : effTun;
        outCode   <= effCode;
        outTunnel <= effTun;
      end
    end
  end

endmodule

// File: rtl/hdr_tagger_dp.sv
module hdr_tagger_dp
  import hdr_tagger_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtl_t                     ctl,
  input  logic [7:0]                 inByte,
  output logic                       secLast,
  output logic [7:0]                 nhByte,
  output logic [OFF_W-1:0]           outOffset,
  output logic [NUM_SLOTS*OFF_W-1:0] startOffsets,
  output logic [NUM_SLOTS-1:0]       startValid
);

  logic [OFF_W-1:0] pos;
  logic [OFF_W-1:0] idx;
  logic [OFF_W-1:0] secLen;
  logic [7:0]       nhReg;

  logic [OFF_W-1:0] effPos;
  logic [OFF_W-1:0] effIdx;
  logic [OFF_W-1:0] effLen;
  logic             lenLoad;
  logic [OFF_W-1:0] lenVal;
  logic             nhCap;
  logic [NUM_SLOTS-1:0] hit;

  assign effPos  = ctl.restart ? '0 : pos;
  assign effIdx  = ctl.restart ? '0 : idx;
  assign effLen  = ctl.restart ? OFF_W'(ETH_LEN) : secLen;
  assign secLast = ctl.take && isBounded(ctl.code) && (effIdx == effLen - 1'b1);
  assign nhByte  = nhReg;
  assign hit     = slotHit(ctl.code);

  // length fields, each read before its region can end
  always_comb begin
    lenLoad = 1'b0;
    lenVal  = effLen;
    case (ctl.code)
      SEC_IPV4: if (effIdx == OFF_W'(0)) begin
        lenLoad = 1'b1;
        lenVal  = OFF_W'({inByte[3:0], 2'b00});
      end
      SEC_HOPOPT, SEC_ROUTE, SEC_DSTOPT: if (effIdx == OFF_W'(1)) begin
        lenLoad = 1'b1;
        lenVal  = (OFF_W'(inByte) + 1'b1) << 3;
      end
      SEC_AUTH: if (effIdx == OFF_W'(1)) begin
        lenLoad = 1'b1;
        lenVal  = (OFF_W'(inByte) + OFF_W'(2)) << 2;
      end
      SEC_TCP: if (effIdx == OFF_W'(12)) begin
        lenLoad = 1'b1;
        lenVal  = OFF_W'({inByte[7:4], 2'b00});
      end
      default: lenLoad = 1'b0;
    endcase
  end

  // byte naming the following region (ethertype high byte for Ethernet)
  always_comb begin
    case (ctl.code)
      SEC_ETH:  nhCap = (effIdx == OFF_W'(12));
      SEC_IPV4: nhCap = (effIdx == OFF_W'(9));
      SEC_IPV6: nhCap = (effIdx == OFF_W'(6));
      default:  nhCap = isExtHdr(ctl.code) && (effIdx == '0);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos       <= '0;
      idx       <= '0;
      secLen    <= OFF_W'(ETH_LEN);
      nhReg     <= '0;
      outOffset <= '0;
    end else if (ctl.take) begin
      pos       <= effPos + 1'b1;
      idx       <= secLast ? '0 : effIdx + 1'b1;
      secLen    <= secLast ? OFF_W'(entryLen(ctl.nextCode)) : (lenLoad ? lenVal : effLen);
      nhReg     <= nhCap ? inByte : nhReg;
      outOffset <= effIdx;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic             vld;
    logic [OFF_W-1:0] off;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld <= 1'b0;
        off <= '0;
      end else if (ctl.take) begin
        if (ctl.restart) begin
          vld <= 1'b0;
          off <= '0;
        end else if (effIdx == '0 && hit[s] && !vld) begin
          vld <= 1'b1;
          off <= effPos;
        end
      end
    end
    assign startValid[s]                  = vld;
    assign startOffsets[s*OFF_W +: OFF_W] = off;
  end

endmodule

// File: rtl/hdr_section_tagger.sv
module hdr_section_tagger
  import hdr_tagger_pkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int TUNNEL_MAX = 3,
  parameter int TUN_W      = $clog2(TUNNEL_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       inSof,
  input  logic                       inEof,
  input  logic [7:0]                 inByte,
  output logic                       outValid,
  output logic [7:0]                 outCode,
  output logic [OFF_W-1:0]           outOffset,
  output logic [TUN_W-1:0]           outTunnel,
  output logic [NUM_SLOTS*OFF_W-1:0] startOffsets,
  output logic [NUM_SLOTS-1:0]       startValid
);

  dpCtl_t     ctl;
  logic       secLast;
  logic [7:0] nhByte;

  hdr_tagger_ctrl #(.TUNNEL_MAX(TUNNEL_MAX), .TUN_W(TUN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inByte(inByte), .secLast(secLast), .nhByte(nhByte), .ctl(ctl),
    .outValid(outValid), .outCode(outCode), .outTunnel(outTunnel)
  );

  hdr_tagger_dp #(.OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inByte(inByte), .secLast(secLast),
    .nhByte(nhByte), .outOffset(outOffset), .startOffsets(startOffsets),
    .startValid(startValid)
  );

endmodule

// File: rtl/hdr_section_tagger_chk.sv
module hdr_section_tagger_chk
  import hdr_tagger_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int TUN_W = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 outValid,
  input logic [7:0]           outCode,
  input logic [OFF_W-1:0]     outOffset,
  input logic [TUN_W-1:0]     outTunnel,
  input logic [NUM_SLOTS-1:0] startValid
);

  logic             seen;
  logic [7:0]       lastCode;
  logic [OFF_W-1:0] lastOff;
  logic [TUN_W-1:0] lastTun;
  logic             lastTerminal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen     <= 1'b0;
      lastCode <= SEC_UNKNOWN;
      lastOff  <= '0;
      lastTun  <= '0;
    end else if (outValid) begin
      seen     <= 1'b1;
      lastCode <= outCode;
      lastOff  <= outOffset;
      lastTun  <= outTunnel;
    end
  end

  assign lastTerminal = (lastCode == SEC_PAYLOAD) || (lastCode == SEC_ESP) ||
                        (lastCode == SEC_UNKNOWN) || (lastCode == SEC_ICMP4) ||
                        (lastCode == SEC_ICMP6);

  p_offset_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOffset != '0) |->
      (seen && outOffset == lastOff + 1'b1 && outCode == lastCode));

  p_eth_region_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == SEC_ETH) |-> (outOffset < OFF_W'(14) && outTunnel == '0));

  p_tunnel_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seen && outTunnel != lastTun) |->
      ((outTunnel == lastTun + 1'b1 && outOffset == '0 &&
        (outCode == SEC_IPV4 || outCode == SEC_IPV6)) ||
       (outTunnel == '0 && outCode == SEC_ETH)));

  p_terminal_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seen && lastTerminal && outCode != SEC_ETH) |-> (outCode == lastCode));

  p_sof_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == SEC_ETH && outOffset == '0) |-> (startValid == '0));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(startValid) & ~startValid)) |->
      (outValid && outCode == SEC_ETH && outOffset == '0));

endmodule

bind hdr_section_tagger hdr_section_tagger_chk #(.OFF_W(OFF_W), .TUN_W(TUN_W)) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outCode(outCode),
  .outOffset(outOffset), .outTunnel(outTunnel), .startValid(startValid)
);

// File: tb/hdr_section_tagger_bench.sv
module hdr_section_tagger_bench;

  localparam int OFF_W = 16;
  localparam int TW    = 2;
  localparam int NS    = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic outValid;
  logic [7:0] outCode;
  logic [OFF_W-1:0] outOffset;
  logic [TW-1:0] outTunnel;
  logic [NS*OFF_W-1:0] startOffsets;
  logic [NS-1:0] startValid;

  hdr_section_tagger u_hdr_section_tagger (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inByte(inByte), .outValid(outValid), .outCode(outCode), .outOffset(outOffset),
    .outTunnel(outTunnel), .startOffsets(startOffsets), .startValid(startValid)
  );

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [7:0] frm[$];
  int expCode[0:1023];
  int expOff[0:1023];
  int expTun[0:1023];
  int expStart[0:NS-1];
  bit expVld[0:NS-1];
  int pend = -1;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int slotFor(int c);
    case (c)
      41: return 0;   4: return 1;
      6, 17, 1, 58: return 2;
      254: return 3;  0: return 4;  43: return 5;  44: return 6;
      60: return 7;   51: return 8; 50: return 9;
      default: return -1;
    endcase
  endfunction

  function automatic string reqFor(int c);
    case (c)
      253: return "R2";
      4, 41: return "R4";
      0, 43, 44, 60, 51: return "R5";
      6, 17, 254: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic bit bounded(int c);
    return c == 253 || c == 4 || c == 41 || c == 0 || c == 43 || c == 44 ||
           c == 60 || c == 51 || c == 6 || c == 17;
  endfunction

  function automatic bit plain(int c);
    return c == 0 || c == 1 || c == 6 || c == 17 || c == 43 || c == 44 ||
           c == 50 || c == 51 || c == 58 || c == 60;
  endfunction

  // header walk over the whole frame: fills the per-byte expectations
  task automatic modelFrame();
    int n, p, cur, tun, len, nh, et;
    n = frm.size();
    for (int s = 0; s < NS; s++) begin expVld[s] = 0; expStart[s] = 0; end
    for (int i = 0; i < 14 && i < n; i++) begin
      expCode[i] = 253; expOff[i] = i; expTun[i] = 0;
    end
    et  = {frm[12], frm[13]};
    cur = (et == 16'h0800) ? 4 : (et == 16'h86DD) ? 41 : 255;
    tun = 0;
    p   = 14;
    while (p < n) begin
      int sl;
      sl = slotFor(cur);
      if (sl >= 0 && !expVld[sl]) begin expVld[sl] = 1; expStart[sl] = p; end
      if (!bounded(cur)) begin
        for (int i = p; i < n; i++) begin
          expCode[i] = cur; expOff[i] = i - p; expTun[i] = tun;
        end
        break;
      end
      nh = -1;
      case (cur)
        4:  begin len = (frm[p] & 15) * 4; nh = frm[p+9]; end
        41: begin len = 40; nh = frm[p+6]; end
        0, 43, 60: begin len = (frm[p+1] + 1) * 8; nh = frm[p]; end
        44: begin len = 8; nh = frm[p]; end
        51: begin len = (frm[p+1] + 2) * 4; nh = frm[p]; end
        6:  len = (frm[p+12] >> 4) * 4;
        default: len = 8;
      endcase
      for (int i = 0; i < len && p + i < n; i++) begin
        expCode[p+i] = cur; expOff[p+i] = i; expTun[p+i] = tun;
      end
      p += len;
      if (cur == 6 || cur == 17) cur = 254;
      else if (nh == 4 || nh == 41) begin
        if (tun == 3) cur = 255;
        else begin cur = nh; tun++; end
      end else if (plain(nh)) cur = nh;
      else cur = 255;
    end
  endtask

  task automatic checkPrev();
    if (pend < 0) chk("R1", "no tag expected", outValid, 0);
    else begin
      chk("R1", "tag present", outValid, 1);
      chk(reqFor(expCode[pend]), $sformatf("code byte %0d", pend), outCode, expCode[pend]);
      chk("R3", $sformatf("offset byte %0d", pend), outOffset, expOff[pend]);
      chk("R8", $sformatf("tunnel byte %0d", pend), outTunnel, expTun[pend]);
      if (pend == 0) chk("R10", "records cleared at frame start", startValid, 0);
    end
  endtask

  task automatic checkStarts();
    for (int s = 0; s < NS; s++) begin
      chk("R9", $sformatf("slot %0d valid", s), startValid[s], expVld[s]);
      if (expVld[s])
        chk("R9", $sformatf("slot %0d offset", s), startOffsets[s*OFF_W +: OFF_W], expStart[s]);
    end
  endtask

  task automatic runFrame(int gap, int cnt);
    int n;
    n = frm.size();
    modelFrame();
    for (int i = 0; i < cnt; i++) begin
      if (gap > 0 && i > 0 && i % gap == 0) begin
        @(negedge clk); checkPrev();
        inValid = 0; inSof = 0; inEof = 0; pend = -1;
      end
      @(negedge clk); checkPrev();
      inValid = 1; inSof = (i == 0); inEof = (cnt == n && i == n - 1);
      inByte = frm[i]; pend = i;
    end
    @(negedge clk); checkPrev();
    inValid = 0; inSof = 0; inEof = 0; pend = -1;
    if (cnt == n) checkStarts();
  endtask

  task automatic strayBytes(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); checkPrev();
      inValid = 1; inSof = 0; inEof = 0; inByte = 8'h45; pend = -1;
    end
    @(negedge clk); checkPrev();
    inValid = 0;
  endtask

  task automatic mac(logic [15:0] et);
    frm.delete();
    for (int i = 0; i < 12; i++) frm.push_back(8'h10 + 8'(i));
    frm.push_back(et[15:8]); frm.push_back(et[7:0]);
  endtask
  task automatic v4(int ihl, logic [7:0] proto);
    for (int i = 0; i < ihl * 4; i++)
      frm.push_back(i == 0 ? {4'h4, 4'(ihl)} : i == 9 ? proto : 8'hC0 + 8'(i));
  endtask
  task automatic v6(logic [7:0] nh);
    for (int i = 0; i < 40; i++)
      frm.push_back(i == 0 ? 8'h60 : i == 6 ? nh : 8'h70 + 8'(i));
  endtask
  task automatic ext(logic [7:0] nh, int len);
    for (int i = 0; i < (len + 1) * 8; i++)
      frm.push_back(i == 0 ? nh : i == 1 ? 8'(len) : 8'hE0 ^ 8'(i));
  endtask
  task automatic frag(logic [7:0] nh);
    for (int i = 0; i < 8; i++) frm.push_back(i == 0 ? nh : 8'h90 + 8'(i));
  endtask
  task automatic auth(logic [7:0] nh, int len);
    for (int i = 0; i < (len + 2) * 4; i++)
      frm.push_back(i == 0 ? nh : i == 1 ? 8'(len) : 8'hB0 + 8'(i));
  endtask
  task automatic tcp(int doff);
    for (int i = 0; i < doff * 4; i++)
      frm.push_back(i == 12 ? {4'(doff), 4'h0} : 8'h30 + 8'(i));
  endtask
  task automatic udp();
    for (int i = 0; i < 8; i++) frm.push_back(8'h50 + 8'(i));
  endtask
  task automatic pay(int n);
    for (int i = 0; i < n; i++) frm.push_back(8'hAA ^ 8'(i));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset outValid", outValid, 0);
    chk("R9", "reset record flags", startValid, 0);
    rstN = 1'b1;

    // R4 R6: plain IPv4 + TCP + payload
    mac(16'h0800); v4(5, 8'h06); tcp(5); pay(10); runFrame(0, frm.size());
    // R1: stray bytes outside a frame
    strayBytes(3);
    // R4 R6: IPv4 with options + UDP
    mac(16'h0800); v4(7, 8'h11); udp(); pay(6); runFrame(0, frm.size());
    // R5 R9: full extension chain, second Destination header must not overwrite
    mac(16'h86DD); v6(8'h00); ext(8'h3C, 0); ext(8'h2B, 0); ext(8'h2C, 1);
    frag(8'h3C); ext(8'h33, 0); auth(8'h06, 1); tcp(8); pay(5);
    runFrame(0, frm.size());
    // R1 R3: same frame with idle gaps
    runFrame(3, frm.size());
    // R7: ESP tail
    mac(16'h86DD); v6(8'h32); pay(20); runFrame(0, frm.size());
    // R8: tunnel stack up to the cap, fifth header unknown
    mac(16'h0800); v4(5, 8'h04); v4(5, 8'h29); v6(8'h29); v6(8'h04); pay(25);
    runFrame(0, frm.size());
    // R2: foreign ethertype
    mac(16'h8100); pay(12); runFrame(0, frm.size());
    // R7: ICMPv6 and ICMPv4
    mac(16'h86DD); v6(8'h3A); pay(10); runFrame(0, frm.size());
    mac(16'h0800); v4(6, 8'h01); pay(8); runFrame(0, frm.size());
    // R7: no-next-header value and unrecognised value after an extension
    mac(16'h86DD); v6(8'h3B); pay(8); runFrame(0, frm.size());
    mac(16'h86DD); v6(8'h3C); ext(8'h63, 1); pay(6); runFrame(0, frm.size());
    // R10: frame cut inside a tunnelled header, then a fresh frame
    mac(16'h0800); v4(5, 8'h04); v4(5, 8'h06); tcp(5); pay(4); runFrame(0, 40);
    mac(16'h0800); v4(5, 8'h06); tcp(5); pay(3); runFrame(0, frm.size());

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule